// File: doc/BRIEF.md
# Ternary Signature Match Engine with Jumping Stream Window

This block searches a byte stream for stored payload signatures. It holds a small table of ternary entries. Every bit of every entry is a two-bit cell that can require a 0, require a 1, or accept either value. Incoming bytes shift into a window that is several bytes wide. Each time the window has moved forward by a fixed number of bytes, its contents form a search key. That key is compared against every entry in the same cycle.

Each lookup returns three things: a vector with one bit per entry showing every entry that matched, the index of the winning entry, and a flag that says whether anything matched at all. The entry with the lowest index wins. Signatures are loaded through a plain write port. The write port stays usable while the stream runs, so the table can change without stopping the search.

The stream input is valid/ready. The block never applies back-pressure: the table lookup is fully pipelined and takes one byte per cycle. For that reason `in_ready` is held high outside reset, and a byte moves whenever `in_valid` is high. The result outputs and the write port are plain signals with no handshake. A result is present for exactly one cycle, the cycle in which `res_valid` is high.

Top module: `tcam_stream_matcher`

## Requirements
- R1: Cell j of an entry sits at `wr_cells[2j+1:2j]` and is compared with key bit j (bit 0 is the least significant bit of the newest byte). Code 2'b00 accepts either key value, 2'b01 accepts only a 1, and 2'b10 accepts only a 0.
- R2: An entry never matches if any of its cells holds code 2'b11. An entry whose valid bit was written as 0 never matches.
- R3: In a result cycle, bit i of `res_vec` is 1 exactly when entry i matches the key. All entries are evaluated in the same lookup.
- R4: `res_hit` is 1 when any bit of `res_vec` is set. `res_idx` is then the lowest set index. When `res_hit` is 0, `res_idx` is 0.
- R5: Suppose the byte that completes a window is accepted at clock edge k. Then the result is registered at edge k+1 and `res_valid` is high only in the cycle that follows. Outside result cycles, `res_valid`, `res_hit`, `res_idx` and `res_vec` are all 0.
- R6: An entry with fixed leading bytes and don't-care trailing bytes matches every key that starts with those leading bytes, whatever the trailing bytes hold.
- R7: A write captured at the same edge as a lookup result does not affect that result. The next lookup does see the new contents.
- R8: The key puts the oldest window byte in its most significant bits. After reset, the first lookup fires when the KEY_BYTES-th byte is accepted. After that, a lookup fires on every STRIDE-th accepted byte. `in_ready` is 1 whenever reset is not asserted.
- R9: Reset clears every entry's valid bit and drives `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte accepted (high outside reset) |
| in_data | input | 8 | Stream byte |
| wr_en | input | 1 | Write one table entry |
| wr_addr | input | IDX_W | Entry index to write |
| wr_entry_valid | input | 1 | Valid bit stored with the entry |
| wr_cells | input | 2*8*KEY_BYTES | Two-bit cells of the entry |
| res_valid | output | 1 | Lookup result cycle |
| res_hit | output | 1 | At least one entry matched |
| res_idx | output | IDX_W | Lowest matching entry index |
| res_vec | output | ENTRIES | One bit per matching entry |

## Verification
Two functions can fall in the same cycle: a table write, and the capture of a lookup result. The bench provokes this by finishing a window with a key that misses every entry. During the cycle when that key is being compared, it writes a catch-all entry. That result must still report no hit. The next lookup must report the new entry as the only hit. Multiple matches and priority are judged over a 256-value sweep of trailing bytes against overlapping entries. A bench model computes each expected vector by masked comparison.

// File: rtl/tcam_pkg.sv
`timescale 1ns/1ps
package tcam_pkg;
  localparam logic [1:0] CELL_ANY  = 2'b00;
  localparam logic [1:0] CELL_ONE  = 2'b01;
  localparam logic [1:0] CELL_ZERO = 2'b10;
  localparam logic [1:0] CELL_BAD  = 2'b11;

  // Does one ternary cell accept one key bit?
  function automatic logic cell_accepts(input logic [1:0] code, input logic kb);
    case (code)
      CELL_ANY:  return 1'b1;
      CELL_ONE:  return kb;
      CELL_ZERO: return !kb;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tcam_window.sv
`timescale 1ns/1ps
module tcam_window #(
  parameter int KEY_BYTES = 4,
  parameter int STRIDE    = 2,
  parameter int KEY_BITS  = 8 * KEY_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  output logic                key_vld,
  output logic [KEY_BITS-1:0] key
);
  localparam int CNT_W = $clog2(KEY_BYTES + 1);

  logic [CNT_W-1:0] need_q;

  assign in_ready = rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key     <= '0;
      key_vld <= 1'b0;
      need_q  <= CNT_W'(KEY_BYTES);
    end else if (in_valid) begin
      key <= KEY_BITS'({key, in_data});
      if (need_q == CNT_W'(1)) begin
        key_vld <= 1'b1;
        need_q  <= CNT_W'(STRIDE);
      end else begin
        key_vld <= 1'b0;
        need_q  <= need_q - CNT_W'(1);
      end
    end else begin
      key_vld <= 1'b0;
    end
  end

  // R8: a key is only issued right after a byte was taken
  a_r8_key_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld |-> $past(in_valid));
  // R8: byte counter stays within one window
  a_r8_need_range: assert property (@(posedge clk) disable iff (!rst_n)
    (need_q >= CNT_W'(1)) && (need_q <= CNT_W'(KEY_BYTES)));
endmodule

// File: rtl/tcam_store.sv
`timescale 1ns/1ps
module tcam_store
  import tcam_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int KEY_BITS  = 32,
  parameter int IDX_W     = 3,
  parameter int CELL_BITS = 2 * KEY_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_addr,
  input  logic                 wr_entry_valid,
  input  logic [CELL_BITS-1:0] wr_cells,
  input  logic [KEY_BITS-1:0]  key,
  output logic [ENTRIES-1:0]   match_vec
);
  logic [CELL_BITS-1:0] cells_q [ENTRIES];
  logic [ENTRIES-1:0]   vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) cells_q[e] <= '0;
    end else if (wr_en) begin
      cells_q[wr_addr] <= wr_cells;
      vld_q[wr_addr]   <= wr_entry_valid;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic row_ok;
    logic row_bad;
    always_comb begin
      row_ok = vld_q[g];
      for (int b = 0; b < KEY_BITS; b++)
        if (!cell_accepts(cells_q[g][2*b +: 2], key[b])) row_ok = 1'b0;
    end
    always_comb begin
      row_bad = 1'b0;
      for (int b = 0; b < KEY_BITS; b++)
        if (cells_q[g][2*b +: 2] == CELL_BAD) row_bad = 1'b1;
    end
    assign match_vec[g] = row_ok;

    // R2: illegal cell or cleared valid bit blocks the match line
    a_r2_gated_row: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec[g] |-> (vld_q[g] && !row_bad));
  end
endmodule

// File: rtl/tcam_prio.sv
`timescale 1ns/1ps
module tcam_prio #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] vec,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tcam_stream_matcher.sv
`timescale 1ns/1ps
module tcam_stream_matcher #(
  parameter int ENTRIES   = 8,
  parameter int KEY_BYTES = 4,
  parameter int STRIDE    = 2,
  parameter int IDX_W     = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [7:0]               in_data,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_addr,
  input  logic                     wr_entry_valid,
  input  logic [16*KEY_BYTES-1:0]  wr_cells,
  output logic                     res_valid,
  output logic                     res_hit,
  output logic [IDX_W-1:0]         res_idx,
  output logic [ENTRIES-1:0]       res_vec
);
  localparam int KEY_BITS = 8 * KEY_BYTES;

  logic                key_vld;
  logic [KEY_BITS-1:0] key;
  logic [ENTRIES-1:0]  match_vec;
  logic                found;
  logic [IDX_W-1:0]    win_idx;

  tcam_window #(.KEY_BYTES(KEY_BYTES), .STRIDE(STRIDE), .KEY_BITS(KEY_BITS)) u_window (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .key_vld(key_vld), .key(key));

  tcam_store #(.ENTRIES(ENTRIES), .KEY_BITS(KEY_BITS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_entry_valid(wr_entry_valid), .wr_cells(wr_cells), .key(key),
    .match_vec(match_vec));

  tcam_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .vec(match_vec), .found(found), .idx(win_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_vec   <= '0;
    end else begin
      res_valid <= key_vld;
      res_hit   <= key_vld && found;
      res_idx   <= key_vld ? win_idx : '0;
      res_vec   <= key_vld ? match_vec : '0;
    end
  end

  // R4: the reported winner is itself a match
  a_r4_winner_in_vec: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_vec[res_idx]);
  // R4: no lower-index entry matched
  a_r4_none_below: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> ((res_vec & ((ENTRIES'(1) << res_idx) - ENTRIES'(1))) == '0));
  // R3: hit flag agrees with the match vector
  a_r3_hit_iff_any: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_vec != '0)));
  // R5: outputs quiet between results
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && res_vec == '0 && res_idx == '0));
endmodule

// File: tb/test_tcam_stream_matcher.sv
`timescale 1ns/1ps
module test_tcam_stream_matcher;
  localparam int ENTRIES = 8;
  localparam int KB      = 4;
  localparam int STRIDE  = 2;
  localparam int IW      = 3;
  localparam int KBITS   = 8 * KB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_addr = '0;
  logic wr_entry_valid = 1'b0;
  logic [2*KBITS-1:0] wr_cells = '0;
  logic res_valid, res_hit;
  logic [IW-1:0] res_idx;
  logic [ENTRIES-1:0] res_vec;

  always #5 clk = ~clk;

  tcam_stream_matcher #(.ENTRIES(ENTRIES), .KEY_BYTES(KB), .STRIDE(STRIDE)) i_tcam_stream_matcher (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_entry_valid(wr_entry_valid), .wr_cells(wr_cells),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_vec(res_vec));

  int checks = 0;
  int failures = 0;

  // bench model of the table
  bit [KBITS-1:0] m_care [ENTRIES];
  bit [KBITS-1:0] m_val  [ENTRIES];
  bit m_bad [ENTRIES];
  bit m_vld [ENTRIES];
  bit [KBITS-1:0] bwin;
  int bneed;

  function automatic bit [ENTRIES-1:0] exp_vec(input bit [KBITS-1:0] k);
    bit [ENTRIES-1:0] v = '0;
    for (int i = 0; i < ENTRIES; i++)
      v[i] = m_vld[i] && !m_bad[i] && (((k ^ m_val[i]) & m_care[i]) == '0);
    return v;
  endfunction

  task automatic check(input string tag, input bit ok, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic check_res(input string tag, input bit [ENTRIES-1:0] e);
    int wi = 0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (e[i]) wi = i;
    check({tag, " valid"}, res_valid == 1'b1, res_valid, 1);
    check({tag, " vec"}, res_vec == e, res_vec, e);
    check({tag, " hit"}, res_hit == (e != 0), res_hit, (e != 0));
    check({tag, " idx"}, res_idx == IW'(wi), res_idx, wi);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bneed = KB;
    bwin = '0;
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 0;
  endtask

  task automatic wr(input int idx, input bit vld, input bit [KBITS-1:0] care,
                    input bit [KBITS-1:0] val, input bit bad);
    bit [2*KBITS-1:0] c = '0;
    for (int j = 0; j < KBITS; j++)
      c[2*j +: 2] = !care[j] ? 2'b00 : (val[j] ? 2'b01 : 2'b10);
    if (bad) c[1:0] = 2'b11;
    @(negedge clk);
    wr_en = 1; wr_addr = IW'(idx); wr_entry_valid = vld; wr_cells = c;
    @(negedge clk);
    wr_en = 0;
    m_care[idx] = care; m_val[idx] = val; m_bad[idx] = bad; m_vld[idx] = vld;
  endtask

  task automatic push(input bit [7:0] b, output bit fired);
    @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
    bwin = {bwin[KBITS-9:0], b};
    if (bneed == 1) begin fired = 1; bneed = STRIDE; end
    else begin fired = 0; bneed--; end
  endtask

  task automatic feed(input bit [7:0] b, input string tag);
    bit f;
    push(b, f);
    if (f) begin
      check("R5 no early result", res_valid == 1'b0, res_valid, 0);
      @(negedge clk);
      check_res(tag, exp_vec(bwin));
    end
  endtask

  // burst monitor
  int pulses = 0;
  int hit_at = -1;
  bit mon_on = 0;
  always @(negedge clk) if (mon_on && res_valid) begin
    pulses++;
    if (res_hit) hit_at = pulses;
  end

  initial begin
    #1500us;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit f;
    do_reset();
    @(negedge clk);
    check("R9 reset res_valid", res_valid == 0, res_valid, 0);
    check("R8 in_ready high", in_ready == 1, in_ready, 1);
    // R9: empty table after reset
    feed(8'h70, "R9"); feed(8'h71, "R9"); feed(8'h72, "R9"); feed(8'h73, "R9");

    // R1 R2 R6 table
    wr(0, 1, 32'hFF00_0000, 32'h7800_0000, 0);
    wr(1, 1, 32'hFFFF_0000, 32'h6162_0000, 0);       // prefix "ab" + two wildcard bytes (R6)
    wr(2, 1, 32'hFFFF_FFFF, 32'h6162_104A, 0);
    wr(3, 1, 32'h0000_0000, 32'h0, 1);               // R2 illegal cell
    wr(4, 0, 32'h0000_0000, 32'h0, 0);               // R2 invalid entry
    wr(5, 1, 32'h0000_0001, 32'h0000_0001, 0);       // R1 code one
    wr(6, 1, 32'h0000_0003, 32'h0000_0002, 0);       // R1 code zero and one
    for (int t = 0; t < 256; t++) begin
      feed(8'h61, "R1 R3 R4");
      feed(8'h62, "R1 R3 R4");
      feed(8'(t), "R6 R2 R3");
      feed(8'(t) ^ 8'h5A, "R6 R2 R3");
    end

    // R7: write during a missing lookup
    push(8'h00, f);
    push(8'h00, f);
    check("R7 lookup fired", f == 1, f, 1);
    wr_en = 1; wr_addr = IW'(7); wr_entry_valid = 1; wr_cells = '0;
    @(negedge clk);
    wr_en = 0;
    check_res("R7 old contents", exp_vec(bwin));
    m_care[7] = '0; m_val[7] = '0; m_bad[7] = 0; m_vld[7] = 1;
    feed(8'h00, "R7 new contents");
    feed(8'h00, "R7 new contents");

    // R2: same entry without the illegal cell now matches
    wr(3, 1, 32'h0, 32'h0, 0);
    feed(8'h11, "R2 revived");
    feed(8'h22, "R2 revived");

    // R8: back-to-back burst, stride and byte order
    do_reset();
    wr(0, 1, 32'hFFFF_FFFF, 32'h3233_3435, 0);
    pulses = 0; hit_at = -1; mon_on = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'h30 + 8'(i);
    end
    @(negedge clk);
    in_valid = 0;
    repeat (4) @(negedge clk);
    mon_on = 0;
    check("R8 lookup count", pulses == 4, pulses, 4);
    check("R8 window order", hit_at == 2, hit_at, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule